// File: doc/BRIEF.md
# Multi-mode interval timer channel

One channel of a programmable interval timer. A single down-counter, advanced once per clock-enable pulse, drives one output line in one of six ways: a latched interrupt at terminal count, a gate-started one-shot, a divide-by-N rate pulse, a square wave, and two one-tick strobes. One strobe starts when the count is loaded. The other starts on a gate edge. The counter counts in binary or in four decimal decades. A loaded value of zero gives the longest period: 65536 ticks in binary, 10000 in decimal.

A separate front end decodes the bus, assembles the count bytes and latches read values. It programs the channel with a mode strobe (`cfg_wr` with `mode` and `bcd`) and then presents a full count with `load`. While a two-byte count is half written, that front end raises `hold`, which freezes the counter until the second byte arrives. The live count is always visible on `count`.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, `out` is 0 and `count` is 0. Without a tick, load, mode write or gate trigger, `count` does not change.
- R2: A `load` pulse puts `count_in` on `count` at the next clock edge. A loaded 0 reaches terminal count after 65536 ticks in binary and after 10000 ticks in decimal. A mode write makes `out` 0 for mode 0 and 1 for every other mode.
- R3: Mode 0: `out` is 0 after a load of N, rises after the N-th tick, and stays 1 until the next load or mode write. The count keeps decrementing and wraps past zero.
- R4: Mode 2: with N >= 2, `out` is 0 for exactly one tick in every N. It is low after tick k when k mod N = N-1, and the count reloads from N after each period.
- R5: Mode 3: with N >= 2, `out` is 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks, repeating. It is low after tick k when k mod N >= N - floor(N/2).
- R6: Mode 4: `out` is 1 after load, 0 for exactly the tick following the N-th tick, then 1 again. The counter then stays at 0.
- R7: Mode 1: a load does not start counting. A rising `gate` (sampled each clock) reloads N and drives `out` to 0. `out` returns to 1 after the N-th tick, and the count holds at 0. A new rising edge retriggers. If a rising edge coincides with terminal count, the retrigger wins: `out` stays 0 and `count` becomes N.
- R8: Mode 5: a rising `gate` after a load starts the count with `out` at 1. `out` is 0 for the one tick after the N-th tick, then 1.
- R9: With `bcd` set, the counter decrements each 4-bit nibble as a decimal digit: 0x0010 becomes 0x0009, and 0x0000 becomes 0x9999.
- R10: While `hold` is 1, ticks are ignored and `count` and `out` do not change.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: The counter moves only on clock edges where `tick` is 1. With ticks on every third clock, the count falls by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one decrement per pulse |
| cfg_wr | input | 1 | Mode write strobe; stops the channel |
| mode | input | 3 | Operating mode 0..7 |
| bcd | input | 1 | 1 selects four-decade decimal counting |
| load | input | 1 | Count load strobe |
| count_in | input | 16 | Initial count value |
| hold | input | 1 | Freezes counting while a count is half written |
| gate | input | 1 | Trigger input for modes 1 and 5 |
| out | output | 1 | Channel output waveform |
| count | output | 16 | Live counter value |

## Verification
The gate retrigger and terminal count can land on the same clock edge in mode 1. The bench provokes this by dropping `gate` one tick before the count expires and raising it so that its sampled rising edge falls exactly on the edge where the count would reach zero. It then expects `out` to stay low and `count` to show the reloaded N. A second overlap covers a tick that arrives together with `load`: the bench keeps `tick` high through the load cycle and requires the loaded value with no decrement.

// File: rtl/interval_timer_channel.sv
module interval_timer_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cfg_wr,
  input  logic [2:0]   mode,
  input  logic         bcd,
  input  logic         load,
  input  logic [W-1:0] count_in,
  input  logic         hold,
  input  logic         gate,
  output logic         out,
  output logic [W-1:0] count
);
  localparam int ND = W / 4;

  logic [2:0]   mode_r;
  logic         bcd_r, run, armed, strobe, gate_q;
  logic [W-1:0] cnt, init;

  function automatic logic [W-1:0] dec_val(input logic [W-1:0] v, input logic b);
    logic [W-1:0] r;
    logic         brw;
    if (!b) return v - 1'b1;
    r   = v;
    brw = 1'b1;
    for (int i = 0; i < ND; i++) begin
      if (brw) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] half_val(input logic [W-1:0] v, input logic b);
    logic [W-1:0] r;
    if (v == '0) begin
      r = '0;
      if (b) r[W-1 -: 4] = 4'd5;
      else   r[W-1]      = 1'b1;
      return r;
    end
    if (!b) return v >> 1;
    r = '0;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = v[4*i +: 4] >> 1;
      if (i < ND - 1 && v[4*(i+1)]) r[4*i +: 4] = r[4*i +: 4] + 4'd5;
    end
    return r;
  endfunction

  wire [2:0]   mode_m = (mode > 3'd5) ? {1'b0, mode[1:0]} : mode;
  wire         trig   = gate & ~gate_q & armed & (mode_r == 3'd1 || mode_r == 3'd5);
  wire [W-1:0] nxt    = dec_val(cnt, bcd_r);
  wire [W-1:0] half   = half_val(init, bcd_r);

  assign count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      bcd_r  <= 1'b0;
      run    <= 1'b0;
      armed  <= 1'b0;
      strobe <= 1'b0;
      gate_q <= 1'b0;
      out    <= 1'b0;
      cnt    <= '0;
      init   <= '0;
    end else begin
      gate_q <= gate;
      if (cfg_wr) begin
        mode_r <= mode_m;
        bcd_r  <= bcd;
        run    <= 1'b0;
        armed  <= 1'b0;
        strobe <= 1'b0;
        out    <= (mode_m != 3'd0);
      end else if (load) begin
        init   <= count_in;
        cnt    <= count_in;
        armed  <= 1'b1;
        strobe <= 1'b0;
        case (mode_r)
          3'd0:       begin run <= 1'b1; out <= 1'b0; end
          3'd1, 3'd5: begin run <= 1'b0; out <= 1'b1; end
          default:    begin run <= 1'b1; out <= 1'b1; end
        endcase
      end else if (trig) begin
        cnt    <= init;
        run    <= 1'b1;
        strobe <= 1'b0;
        out    <= (mode_r != 3'd1);
      end else if (tick && !hold) begin
        if (strobe) begin
          out    <= 1'b1;
          strobe <= 1'b0;
        end
        if (run) begin
          cnt <= nxt;
          case (mode_r)
            3'd0: if (nxt == '0) out <= 1'b1;
            3'd1: if (nxt == '0) begin out <= 1'b1; run <= 1'b0; end
            3'd2: begin
              if (nxt == '0) begin cnt <= init; out <= 1'b1; end
              else if (nxt == W'(1)) out <= 1'b0;
            end
            3'd3: begin
              if (nxt == '0) begin cnt <= init; out <= 1'b1; end
              else if (nxt == half) out <= 1'b0;
            end
            default: if (nxt == '0) begin out <= 1'b0; run <= 1'b0; strobe <= 1'b1; end
          endcase
        end
      end
    end
  end

  a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !load && !trig && !tick) |=> $stable(cnt));

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg_wr) |=> (cnt == $past(count_in)));

  a_r3_tc_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == 3'd0 && out && !cfg_wr && !load) |=> out);

  a_r4_rate_low_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == 3'd2 && !out && tick && !hold && !cfg_wr && !load) |=> out);

  a_r6_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r >= 3'd4 && !out && tick && !hold && !cfg_wr && !load && !trig) |=> out);

  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cfg_wr && !load && !trig) |=> ($stable(cnt) && $stable(out)));
endmodule

// File: tb/tb_interval_timer_channel.sv
module tb_interval_timer_channel;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b1, cfg_wr = 1'b0, bcd = 1'b0;
  logic        load = 1'b0, hold = 1'b0, gate = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] count_in = '0;
  logic        out;
  logic [15:0] count;
  int checks = 0, errors = 0;
  bit done = 0;

  interval_timer_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr), .mode(mode), .bcd(bcd),
    .load(load), .count_in(count_in), .hold(hold), .gate(gate), .out(out), .count(count)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg(int m, bit b);
    @(negedge clk); cfg_wr = 1'b1; mode = 3'(m); bcd = b;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic ld(logic [15:0] v);
    @(negedge clk); load = 1'b1; count_in = v;
    @(negedge clk); load = 1'b0;
  endtask

  function automatic int exp_out(int m, int k, int n);
    case (m)
      0: return (k >= n) ? 1 : 0;
      2: return ((k % n) == n - 1) ? 0 : 1;
      3: return ((k % n) >= n - n / 2) ? 0 : 1;
      default: return (k == n) ? 0 : 1;
    endcase
  endfunction

  task automatic run_seq(string req, int m, bit b, logic [15:0] enc, int n, int len);
    int mm;
    mm = (m == 6) ? 2 : (m == 7) ? 3 : m;
    cfg(m, b);
    chk(req, out, (mm == 0) ? 0 : 1);
    ld(enc);
    chk(req, count, enc);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      chk(req, out, exp_out(mm, k, n));
      if (mm == 0 && !b) chk(req, count, (n - k) & 16'hFFFF);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick = 1'b0;
    @(negedge clk);
    chk("R1 reset out", out, 0);
    chk("R1 reset count", count, 0);
    repeat (3) @(negedge clk);
    chk("R1 idle count", count, 0);
    tick = 1'b1;

    for (int n = 2; n <= 7; n++) begin
      run_seq("R3 mode0", 0, 0, 16'(n), n, 2 * n + 3);
      run_seq("R4 mode2", 2, 0, 16'(n), n, 3 * n + 1);
      run_seq("R5 mode3", 3, 0, 16'(n), n, 3 * n + 1);
      run_seq("R6 mode4", 4, 0, 16'(n), n, n + 4);
    end
    run_seq("R11 mode6", 6, 0, 16'd4, 4, 13);
    run_seq("R11 mode7", 7, 0, 16'd5, 5, 16);
    run_seq("R5 mode3 bcd", 3, 1, 16'h0010, 10, 31);
    run_seq("R4 mode2 bcd", 2, 1, 16'h0012, 12, 25);

    cfg(0, 0); ld(16'd0);
    for (int k = 1; k <= 65536; k++) begin
      @(negedge clk);
      if (k == 1) chk("R2 zero count", count, 16'hFFFF);
      if (k == 65535) chk("R2 zero before tc", out, 0);
      if (k == 65536) chk("R2 zero tc", out, 1);
    end

    cfg(0, 1); ld(16'h0010);
    @(negedge clk); chk("R9 bcd borrow", count, 16'h0009);
    repeat (9) @(negedge clk);
    chk("R9 bcd tc", out, 1);
    chk("R9 bcd zero", count, 0);
    @(negedge clk); chk("R9 bcd wrap", count, 16'h9999);
    cfg(0, 1); ld(16'h0000);
    @(negedge clk); chk("R2 bcd zero first", count, 16'h9999);
    repeat (9998) @(negedge clk);
    chk("R2 bcd zero before tc", out, 0);
    @(negedge clk); chk("R2 bcd zero tc", out, 1);

    cfg(0, 0); ld(16'd20);
    repeat (3) @(negedge clk);
    chk("R10 pre hold", count, 17);
    hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R10 hold count", count, 17); chk("R10 hold out", out, 0);
    end
    hold = 1'b0;
    @(negedge clk); chk("R10 release", count, 16);

    cfg(0, 0); ld(16'd10);
    exp_cnt = 10;
    for (int i = 0; i < 9; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
      if (tick) exp_cnt--;
      chk("R12 sparse tick", count, exp_cnt);
    end
    tick = 1'b1;

    cfg(1, 0);
    chk("R2 cfg level", out, 1);
    ld(16'd5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 wait gate", count, 5); chk("R7 wait out", out, 1);
    end
    gate = 1'b1;
    @(negedge clk); chk("R7 trig out", out, 0); chk("R7 trig count", count, 5);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R7 oneshot out", out, (k >= 5) ? 1 : 0);
      chk("R7 oneshot count", count, (k >= 5) ? 0 : 5 - k);
    end
    gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk); chk("R7 retrig out", out, 0); chk("R7 retrig count", count, 5);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) gate = 1'b0;
    end
    chk("R7 near tc", count, 1);
    gate = 1'b1;
    @(negedge clk);
    chk("R7 coincide out", out, 0);
    chk("R7 coincide count", count, 5);
    gate = 1'b0;

    cfg(5, 0); ld(16'd3);
    @(negedge clk); chk("R8 no start", count, 3);
    gate = 1'b1;
    @(negedge clk); chk("R8 trig out", out, 1); chk("R8 trig count", count, 3);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R8 strobe out", out, (k == 3) ? 0 : 1);
    end
    gate = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule